// File: doc/BRIEF.md
# Overlay Color Key Compositor

This block merges two display planes, one pixel pair per clock. The primary plane and the overlay plane are presented together in lockstep under a single valid flag. One registered output pixel comes out per valid input. The choice of which pixel to show comes from a color key. The key is a lower bound, an upper bound and a per-channel enable mask, and it is applied in one of three modes.

- **Off:** the overlay is always shown.
- **Overlay-transparent (source) keying:** overlay pixels that fall inside the key are hidden, so the primary pixel shows through.
- **Primary-replace (destination) keying:** primary pixels that equal the key are replaced by the overlay pixel.

The two keying modes can never be active together.

Software programs the key through a small register port. It can read the key back at any time. Writes go to a shadow set. The shadow set is copied into the active set only on a frame-start pulse, so one frame is always composited with a single, consistent key.

A surface-format input chooses how source keying compares overlay pixels. For RGB surfaces it uses exact match against the lower bound. For other surfaces it uses a range compare.

Top module: `ckey_compositor`

## Requirements
- R1: After reset, `out_valid` is 0, the lower bound, upper bound and mask read back as 0, and the mode register reads back 0x1 (off).
- R2: Register addresses are: 0 = lower bound (32 bits), 1 = upper bound (32 bits), 2 = channel mask (bits 3:0, upper bits read 0), 3 = mode flags. A write is visible on `cfg_rdata` from the cycle after it; `cfg_rdata` follows `cfg_addr` combinationally.
- R3: A mode write decodes flag bit 1 as primary-replace and bit 2 as overlay-transparent. With bit 1 set the mode becomes primary-replace, else with bit 2 set it becomes overlay-transparent, else it becomes off (bit 0 or no bit).
- R4: A mode write with both bit 1 and bit 2 set is rejected, and the stored mode is left unchanged.
- R5: Mode readback is one-hot: 0x1 off, 0x2 primary-replace, 0x4 overlay-transparent. All other bits read 0.
- R6: In off mode the output pixel equals the overlay pixel.
- R7: In overlay-transparent mode with `surf_rgb`=0, the primary pixel is output when every enabled channel of the overlay pixel lies in [lower, upper] inclusive; otherwise the overlay pixel is output.
- R8: In overlay-transparent mode with `surf_rgb`=1, the upper bound is ignored. The primary pixel is output only when every enabled overlay channel equals the lower bound's channel.
- R9: In primary-replace mode, the overlay pixel is output when every enabled primary channel equals the lower bound's channel; otherwise the primary pixel is output. The upper bound is ignored.
- R10: Channel i occupies pixel bits [8i+7:8i] and is enabled by mask bit i. A channel whose mask bit is 0 always counts as matching.
- R11: `out_valid` is `in_valid` delayed by exactly one clock. `out_px` holds its value in cycles with no valid input.
- R12: Register writes change the compositing behaviour only after a `frame_start` pulse. A pixel in the same cycle as the pulse, or any earlier pixel, uses the previous key. The first pixel in a later cycle uses the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (shadow set) |
| frame_start | input | 1 | Frame boundary pulse; loads the active key |
| surf_rgb | input | 1 | 1 = RGB surface (exact-match source keying) |
| in_valid | input | 1 | Pixel pair valid |
| prim_px | input | 32 | Primary plane pixel |
| ovl_px | input | 32 | Overlay plane pixel |
| out_valid | output | 1 | Composited pixel valid |
| out_px | output | 32 | Composited pixel |

## Verification
A corrupted shadow register shows up at once on `cfg_rdata`, in the cycle after the write that should have set it. A wrong active key or mode stays hidden until the next `frame_start`. After that pulse, it shows in the first pixel sent, one clock later at `out_px`. Sweeping every value of one keyed channel, across all modes and both surface formats, exposes an off-by-one at either range bound, or a swapped pair of bounds, within a single sweep. Pushing a pixel before and after a frame pulse shows whether a write leaked past the shadow stage.

// File: rtl/ckey_pkg.sv
package ckey_pkg;
    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam logic [1:0] ADDR_MODE = 2'd3;

    localparam int FLAG_OFF = 0;
    localparam int FLAG_DST = 1;
    localparam int FLAG_SRC = 2;

    typedef enum logic [1:0] {
        KM_OFF = 2'd0,
        KM_DST = 2'd1,
        KM_SRC = 2'd2
    } key_mode_e;
endpackage

// File: rtl/ckey_regs.sv
module ckey_regs
    import ckey_pkg::*;
#(
    parameter int PIX_W = 32,
    parameter int N_CH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [PIX_W-1:0] cfg_wdata,
    output logic [PIX_W-1:0] cfg_rdata,
    input  logic             frame_start,
    output logic [PIX_W-1:0] act_lo,
    output logic [PIX_W-1:0] act_hi,
    output logic [N_CH-1:0]  act_mask,
    output key_mode_e        act_mode,
    output key_mode_e        shd_mode
);
    typedef struct packed {
        logic [PIX_W-1:0] lo;
        logic [PIX_W-1:0] hi;
        logic [N_CH-1:0]  mask;
        key_mode_e        mode;
    } key_set_t;

    typedef struct packed {
        key_set_t shd;
        key_set_t act;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_LO:   st_d.shd.lo   = cfg_wdata;
                ADDR_HI:   st_d.shd.hi   = cfg_wdata;
                ADDR_MASK: st_d.shd.mask = cfg_wdata[N_CH-1:0];
                default: begin
                    // both keying flags at once: reject, keep mode
                    if (!(cfg_wdata[FLAG_DST] && cfg_wdata[FLAG_SRC])) begin
                        st_d.shd.mode = KM_OFF;
                        if (cfg_wdata[FLAG_DST])
                            st_d.shd.mode = KM_DST;
                        else if (cfg_wdata[FLAG_SRC])
                            st_d.shd.mode = KM_SRC;
                    end
                end
            endcase
        end
        if (frame_start)
            st_d.act = st_q.shd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADDR_LO:   cfg_rdata = st_q.shd.lo;
            ADDR_HI:   cfg_rdata = st_q.shd.hi;
            ADDR_MASK: cfg_rdata = {{(PIX_W-N_CH){1'b0}}, st_q.shd.mask};
            default: begin
                case (st_q.shd.mode)
                    KM_DST:  cfg_rdata[FLAG_DST] = 1'b1;
                    KM_SRC:  cfg_rdata[FLAG_SRC] = 1'b1;
                    default: cfg_rdata[FLAG_OFF] = 1'b1;
                endcase
            end
        endcase
    end

    assign act_lo   = st_q.act.lo;
    assign act_hi   = st_q.act.hi;
    assign act_mask = st_q.act.mask;
    assign act_mode = st_q.act.mode;
    assign shd_mode = st_q.shd.mode;
endmodule

// File: rtl/ckey_match.sv
module ckey_match #(
    parameter int CH_W = 8,
    parameter int N_CH = 4,
    localparam int PIX_W = CH_W * N_CH
) (
    input  logic [PIX_W-1:0] px,
    input  logic [PIX_W-1:0] lo,
    input  logic [PIX_W-1:0] hi,
    input  logic [N_CH-1:0]  mask,
    input  logic             use_range,
    output logic             hit
);
    logic [N_CH-1:0] ch_ok;

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [CH_W-1:0] c, l, h;
        logic            eq_ok, rng_ok;
        assign c      = px[i*CH_W +: CH_W];
        assign l      = lo[i*CH_W +: CH_W];
        assign h      = hi[i*CH_W +: CH_W];
        assign eq_ok  = (c == l);
        assign rng_ok = (c >= l) && (c <= h);
        assign ch_ok[i] = !mask[i] || (use_range ? rng_ok : eq_ok);
    end

    assign hit = &ch_ok;
endmodule

// File: rtl/ckey_compositor.sv
module ckey_compositor
    import ckey_pkg::*;
#(
    parameter int CH_W = 8,
    parameter int N_CH = 4,
    localparam int PIX_W = CH_W * N_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [PIX_W-1:0] cfg_wdata,
    output logic [PIX_W-1:0] cfg_rdata,
    input  logic             frame_start,
    input  logic             surf_rgb,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] prim_px,
    input  logic [PIX_W-1:0] ovl_px,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_px
);
    logic [PIX_W-1:0] act_lo, act_hi;
    logic [N_CH-1:0]  act_mask;
    key_mode_e        act_mode, shd_mode;
    logic             ovl_hit, prim_hit;

    ckey_regs #(.PIX_W(PIX_W), .N_CH(N_CH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .frame_start(frame_start),
        .act_lo(act_lo), .act_hi(act_hi), .act_mask(act_mask),
        .act_mode(act_mode), .shd_mode(shd_mode)
    );

    ckey_match #(.CH_W(CH_W), .N_CH(N_CH)) u_ovl_match (
        .px(ovl_px), .lo(act_lo), .hi(act_hi), .mask(act_mask),
        .use_range(!surf_rgb), .hit(ovl_hit)
    );

    ckey_match #(.CH_W(CH_W), .N_CH(N_CH)) u_prim_match (
        .px(prim_px), .lo(act_lo), .hi(act_hi), .mask(act_mask),
        .use_range(1'b0), .hit(prim_hit)
    );

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] px;
    } pipe_t;

    pipe_t pp_d, pp_q;

    always_comb begin
        pp_d     = pp_q;
        pp_d.vld = in_valid;
        if (in_valid) begin
            case (act_mode)
                KM_DST:  pp_d.px = prim_hit ? ovl_px : prim_px;
                KM_SRC:  pp_d.px = ovl_hit ? prim_px : ovl_px;
                default: pp_d.px = ovl_px;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign out_valid = pp_q.vld;
    assign out_px    = pp_q.px;
endmodule

// File: rtl/ckey_compositor_chk.sv
module ckey_compositor_chk #(
    parameter int PIX_W = 32,
    parameter int N_CH  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [PIX_W-1:0] cfg_wdata,
    input logic [PIX_W-1:0] cfg_rdata,
    input logic             frame_start,
    input logic             in_valid,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_px,
    input logic [PIX_W-1:0] act_lo,
    input logic [PIX_W-1:0] act_hi,
    input logic [N_CH-1:0]  act_mask,
    input logic [1:0]       act_mode,
    input logic [1:0]       shd_mode
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_px));

    a_r4_reject_both: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd3 && cfg_wdata[1] && cfg_wdata[2]) |=> $stable(shd_mode));

    a_r12_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable({act_lo, act_hi, act_mask, act_mode}));

    a_r5_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 2'd3) |-> ($countones(cfg_rdata) == 1 && cfg_rdata[PIX_W-1:3] == '0));
endmodule

bind ckey_compositor ckey_compositor_chk #(.PIX_W(PIX_W), .N_CH(N_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
    .in_valid(in_valid), .out_valid(out_valid), .out_px(out_px),
    .act_lo(act_lo), .act_hi(act_hi), .act_mask(act_mask),
    .act_mode(act_mode), .shd_mode(shd_mode)
);

// File: tb/test_ckey_compositor.sv
module test_ckey_compositor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        frame_start = 1'b0;
    logic        surf_rgb = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] prim_px = '0;
    logic [31:0] ovl_px = '0;
    logic        out_valid;
    logic [31:0] out_px;

    int checks = 0;
    int fails  = 0;

    // bench model of the key: 0 off, 1 primary-replace, 2 overlay-transparent
    logic [31:0] m_lo = '0, m_hi = '0, a_lo = '0, a_hi = '0;
    logic [3:0]  m_mask = '0, a_mask = '0;
    int          m_mode = 0, a_mode = 0;

    always #10 clk = ~clk;

    ckey_compositor i_ckey_compositor (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_start(frame_start),
        .surf_rgb(surf_rgb), .in_valid(in_valid), .prim_px(prim_px),
        .ovl_px(ovl_px), .out_valid(out_valid), .out_px(out_px)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_exp(input logic [31:0] p, input logic [31:0] o,
                                          input int md, input logic [31:0] lo,
                                          input logic [31:0] hi, input logic [3:0] mk,
                                          input logic rgb);
        logic eqo = 1'b1, rgo = 1'b1, eqp = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (mk[i]) begin
                if (o[8*i +: 8] != lo[8*i +: 8]) eqo = 1'b0;
                if (o[8*i +: 8] < lo[8*i +: 8] || o[8*i +: 8] > hi[8*i +: 8]) rgo = 1'b0;
                if (p[8*i +: 8] != lo[8*i +: 8]) eqp = 1'b0;
            end
        end
        if (md == 1) return eqp ? o : p;
        if (md == 2) return (rgb ? eqo : rgo) ? p : o;
        return o;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            2'd0: m_lo = d;
            2'd1: m_hi = d;
            2'd2: m_mask = d[3:0];
            default: if (!(d[1] && d[2])) m_mode = d[1] ? 1 : (d[2] ? 2 : 0);
        endcase
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        cfg_addr = a;
        #1;
        chk(cfg_rdata === exp, req, cfg_rdata, exp);
    endtask

    function automatic logic [31:0] mode_flags(input int md);
        return (md == 1) ? 32'h2 : ((md == 2) ? 32'h4 : 32'h1);
    endfunction

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        a_lo = m_lo; a_hi = m_hi; a_mask = m_mask; a_mode = m_mode;
    endtask

    task automatic push(input logic [31:0] p, input logic [31:0] o, input logic rgb, input string req);
        logic [31:0] e;
        @(negedge clk);
        in_valid = 1'b1; prim_px = p; ovl_px = o; surf_rgb = rgb;
        e = f_exp(p, o, a_mode, a_lo, a_hi, a_mask, rgb);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, {req, " R11 valid"}, {31'd0, out_valid}, 32'd1);
        chk(out_px === e, req, out_px, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid === 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
        rd_chk(2'd0, 32'd0, "R1 lo");
        rd_chk(2'd1, 32'd0, "R1 hi");
        rd_chk(2'd2, 32'd0, "R1 mask");
        rd_chk(2'd3, 32'h1, "R1 mode");

        // R2 write / readback
        wr(2'd0, 32'hA5C3_4010);
        wr(2'd1, 32'hF0E0_8020);
        wr(2'd2, 32'hFFFF_FFF5);
        rd_chk(2'd0, 32'hA5C3_4010, "R2 lo");
        rd_chk(2'd1, 32'hF0E0_8020, "R2 hi");
        rd_chk(2'd2, 32'h0000_0005, "R2 mask");

        // R3 / R4 / R5 mode decode
        wr(2'd3, 32'h2); rd_chk(2'd3, 32'h2, "R3 dst");
        wr(2'd3, 32'h4); rd_chk(2'd3, 32'h4, "R3 src");
        wr(2'd3, 32'h6); rd_chk(2'd3, 32'h4, "R4 reject both keeps src");
        wr(2'd3, 32'h3); rd_chk(2'd3, 32'h2, "R3 dst with off bit");
        wr(2'd3, 32'h7); rd_chk(2'd3, 32'h2, "R4 reject all keeps dst");
        wr(2'd3, 32'h1); rd_chk(2'd3, 32'h1, "R5 off");
        wr(2'd3, 32'h0); rd_chk(2'd3, 32'h1, "R3 no flag gives off");

        // R12: shadow vs active
        wr(2'd0, 32'h0000_0040);
        wr(2'd1, 32'h0000_0080);
        wr(2'd2, 32'h1);
        wr(2'd3, 32'h4);
        push(32'h1111_1111, 32'h2222_2260, 1'b0, "R12 before frame old key");
        // pixel in the frame_start cycle still uses the old key
        @(negedge clk);
        frame_start = 1'b1; in_valid = 1'b1; prim_px = 32'h1111_1111; ovl_px = 32'h2222_2260; surf_rgb = 1'b0;
        @(negedge clk);
        frame_start = 1'b0; in_valid = 1'b0;
        chk(out_px === 32'h2222_2260, "R12 same-cycle pixel old key", out_px, 32'h2222_2260);
        a_lo = m_lo; a_hi = m_hi; a_mask = m_mask; a_mode = m_mode;
        push(32'h1111_1111, 32'h2222_2260, 1'b0, "R12 after frame new key R7");

        // R11 hold and valid drop
        held = out_px;
        @(negedge clk);
        chk(out_valid === 1'b0, "R11 valid drop", {31'd0, out_valid}, 32'd0);
        chk(out_px === held, "R11 hold", out_px, held);

        // sweeps: every value of channel 0 across modes and formats (R6 R7 R8 R9 R10)
        for (int md = 0; md < 3; md++) begin
            wr(2'd3, (md == 1) ? 32'h2 : ((md == 2) ? 32'h4 : 32'h1));
            wr(2'd0, 32'h5A3C_7740);
            wr(2'd1, 32'hA0C8_9080);
            wr(2'd2, 32'h1);
            frame();
            for (int rgb = 0; rgb < 2; rgb++) begin
                for (int v = 0; v < 256; v++) begin
                    push({24'h9E_8D_7C, v[7:0]}, {24'h31_42_53, v[7:0]}, rgb[0],
                         md == 0 ? "R6 off sweep" : (md == 1 ? "R9 dst sweep" :
                         (rgb == 1 ? "R8 src rgb sweep" : "R7 src range sweep")));
                end
            end
        end

        // R10: all channels enabled, channel-wise edges
        wr(2'd2, 32'hF);
        for (int md = 1; md < 3; md++) begin
            wr(2'd3, md == 1 ? 32'h2 : 32'h4);
            frame();
            for (int k = 0; k < 4; k++) begin
                for (int d = -1; d < 2; d++) begin
                    logic [31:0] o;
                    o = 32'h5A3C_7740;
                    o[8*k +: 8] = o[8*k +: 8] + d[7:0];
                    push(o, o, 1'b0, "R10 all-channel compare");
                    push(o, {o[31:8], 8'hFF}, 1'b1, "R10 rgb per-channel");
                end
            end
            push(32'hA0C8_9080, 32'hA0C8_9080, 1'b0, "R10 upper edge");
            push(32'hA1C8_9080, 32'hA1C8_9080, 1'b0, "R10 above upper");
        end
        // mask 0: everything matches
        wr(2'd2, 32'h0);
        frame();
        push(32'h0123_4567, 32'h89AB_CDEF, 1'b0, "R10 empty mask src");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule